// File: doc/BRIEF.md
# Dual-Chain Serial Configuration Loader for a 16-Channel LED Sink

This block is the digital loading front end of a multi-channel constant-current LED sink. A host reaches it through one serial port made of a shift clock, a data input, a latch strobe and a data output. A mode input steers that port to one of two independent shift chains. The enable chain holds one on/off bit per channel. The trim chain holds a 7-bit brightness code per channel. Each chain has its own holding register. The holding registers drive the analog sinks, and only a strobe updates them, so new data can be shifted in while the outputs keep their current settings.

When the enable chain is strobed, it also takes a parallel load of the per-channel open-LED status. The host reads that status from the serial output while it shifts in the next enable pattern. All serial inputs are sampled on the block's system clock. A serial clock or strobe takes effect at the first system clock edge that sees it high after it was low.

Top module: `led_cfg_loader`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) clears both chains and both holding registers, so `en_q`, `trim_q` and `ser_out` read 0.
- R2: With `mode_sel` = 0, each rising `ser_clk` shifts the 16-stage enable chain one place from `ser_in` toward `ser_out`. After 16 shifts, the first bit sent sits in channel 15's stage, so a pattern is sent channel 15 first.
- R3: With `mode_sel` = 1, each rising `ser_clk` shifts the 112-stage trim chain instead. Channel n's code occupies bits [7n+6:7n] of the chain and of `trim_q`, with bit 7n as LSB, and the first bit sent becomes channel 15's bit 6. The enable chain does not move while `mode_sel` = 1.
- R4: A rising `lat_stb` copies the selected chain into its holding register (`en_q` when `mode_sel` = 0, `trim_q` when `mode_sel` = 1). The other holding register keeps its value.
- R5: Shifting alone never changes `en_q` or `trim_q`. A chain keeps its contents after a strobe, so the old data shifts out as new data shifts in.
- R6: While `mode_sel` = 0 and `lat_stb` = 1, the enable chain loads `open_led`, with stage n taking channel n. The status then leaves on `ser_out` channel 15 first during the next load.
- R7: `ser_out` shows the last stage of the selected chain: enable stage 15 when `mode_sel` = 0 and trim stage 111 when `mode_sel` = 1.
- R8: Rising `ser_clk` edges that arrive while `lat_stb` is high shift neither chain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the serial inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 1 | 0 selects the enable chain, 1 selects the trim chain |
| ser_clk | input | 1 | Serial shift clock, acted on at its rising edge |
| ser_in | input | 1 | Serial data input |
| lat_stb | input | 1 | Latch strobe, copies the selected chain at its rising edge |
| open_led | input | 16 | Per-channel open-LED status, bit n for channel n |
| ser_out | output | 1 | Last stage of the selected chain |
| en_q | output | 16 | Held enable bits, bit n for channel n |
| trim_q | output | 112 | Held trim codes, 7 bits per channel in channel order |

## Verification
The bench looks for bit-order errors. It sends asymmetric patterns and checks single trim fields, so a design that reversed the shift direction or packed a field with its MSB at the wrong end would show scrambled channels. It checks status readback against the status captured at the previous strobe. A design that skipped the parallel load, or loaded the status in reverse, would return the wrong word. It also checks that the other holding register and the idle chain survive a mode switch and a strobe in the other mode, and it sends shift pulses while the strobe is high. A design that let those pulses through would latch a corrupted trim word at the next strobe.

// File: rtl/lcl_pkg.sv
package lcl_pkg;
   parameter int unsigned DEF_CHANNELS = 16;
   parameter int unsigned DEF_TRIM_W   = 7;

   // bits held by a chain that carries a field of w bits per channel
   function automatic int unsigned chain_len(input int unsigned ch, input int unsigned w);
      return ch * w;
   endfunction
endpackage

// File: rtl/lcl_edge_rise.sv
module lcl_edge_rise (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic rise
);
   logic prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 1'b0;
      else        prev <= din;
   end

   assign rise = din & ~prev;
endmodule

// File: rtl/lcl_shift_chain.sv
module lcl_shift_chain #(
   parameter int unsigned LEN = 16
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shift_en,
   input  logic           load_en,
   input  logic           sin,
   input  logic [LEN-1:0] pdata,
   output logic [LEN-1:0] q
);
   logic [LEN-1:0] shifted;

   generate
      if (LEN == 1) begin : g_single
         assign shifted = sin;
      end else begin : g_multi
         assign shifted = {q[LEN-2:0], sin};
      end
   endgenerate

   // parallel load wins over a shift in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (load_en)  q <= pdata;
      else if (shift_en) q <= shifted;
   end
endmodule

// File: rtl/lcl_hold_reg.sv
module lcl_hold_reg #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cap,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (cap) q <= d;
   end
endmodule

// File: rtl/led_cfg_loader.sv
module led_cfg_loader
   import lcl_pkg::*;
#(
   parameter int unsigned CHANNELS = DEF_CHANNELS,
   parameter int unsigned TRIM_W   = DEF_TRIM_W
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         mode_sel,
   input  logic                         ser_clk,
   input  logic                         ser_in,
   input  logic                         lat_stb,
   input  logic [CHANNELS-1:0]          open_led,
   output logic                         ser_out,
   output logic [CHANNELS-1:0]          en_q,
   output logic [CHANNELS*TRIM_W-1:0]   trim_q
);
   localparam int unsigned EN_LEN   = CHANNELS;
   localparam int unsigned TRIM_LEN = chain_len(CHANNELS, TRIM_W);

   generate
      if (CHANNELS < 1) begin : g_bad_channels
         $error("led_cfg_loader: CHANNELS must be at least 1");
      end
      if (TRIM_W < 1) begin : g_bad_trim_w
         $error("led_cfg_loader: TRIM_W must be at least 1");
      end
   endgenerate

   logic                sclk_rise;
   logic                stb_rise;
   logic [EN_LEN-1:0]   en_chain;
   logic [TRIM_LEN-1:0] trim_chain;

   logic en_shift, trim_shift, en_load, en_cap, trim_cap;

   lcl_edge_rise u_sclk_edge (.clk(clk), .rst_n(rst_n), .din(ser_clk), .rise(sclk_rise));
   lcl_edge_rise u_stb_edge  (.clk(clk), .rst_n(rst_n), .din(lat_stb), .rise(stb_rise));

   // steering: shifts are blocked while the strobe is high
   assign en_shift   = ~mode_sel & sclk_rise & ~lat_stb;
   assign trim_shift =  mode_sel & sclk_rise & ~lat_stb;
   assign en_load    = ~mode_sel & lat_stb;
   assign en_cap     = ~mode_sel & stb_rise;
   assign trim_cap   =  mode_sel & stb_rise;

   lcl_shift_chain #(.LEN(EN_LEN)) u_en_chain (
      .clk(clk), .rst_n(rst_n), .shift_en(en_shift), .load_en(en_load),
      .sin(ser_in), .pdata(open_led), .q(en_chain)
   );

   lcl_shift_chain #(.LEN(TRIM_LEN)) u_trim_chain (
      .clk(clk), .rst_n(rst_n), .shift_en(trim_shift), .load_en(1'b0),
      .sin(ser_in), .pdata({TRIM_LEN{1'b0}}), .q(trim_chain)
   );

   lcl_hold_reg #(.W(EN_LEN)) u_en_hold (
      .clk(clk), .rst_n(rst_n), .cap(en_cap), .d(en_chain), .q(en_q)
   );

   lcl_hold_reg #(.W(TRIM_LEN)) u_trim_hold (
      .clk(clk), .rst_n(rst_n), .cap(trim_cap), .d(trim_chain), .q(trim_q)
   );

   assign ser_out = mode_sel ? trim_chain[TRIM_LEN-1] : en_chain[EN_LEN-1];
endmodule

// File: rtl/led_cfg_loader_chk.sv
module led_cfg_loader_chk #(
   parameter int unsigned CHANNELS = 16,
   parameter int unsigned TRIM_W   = 7
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       mode_sel,
   input logic                       lat_stb,
   input logic [CHANNELS-1:0]        open_led,
   input logic [CHANNELS-1:0]        en_q,
   input logic [CHANNELS*TRIM_W-1:0] trim_q,
   input logic [CHANNELS-1:0]        en_chain,
   input logic [CHANNELS*TRIM_W-1:0] trim_chain
);
   logic stb_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stb_prev <= 1'b0;
      else        stb_prev <= lat_stb;
   end

   assert_reset_clear_R1: assert property (@(posedge clk)
      !rst_n |=> (en_q == '0 && trim_q == '0));

   assert_en_chain_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sel |=> $stable(en_chain));

   assert_en_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(!mode_sel && lat_stb && !stb_prev) |=> $stable(en_q));

   assert_trim_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mode_sel && lat_stb && !stb_prev) |=> $stable(trim_q));

   assert_status_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_sel && lat_stb) |=> (en_chain == $past(open_led)));

   assert_no_shift_in_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel && lat_stb) |=> $stable(trim_chain));
endmodule

bind led_cfg_loader led_cfg_loader_chk #(.CHANNELS(CHANNELS), .TRIM_W(TRIM_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .lat_stb(lat_stb),
   .open_led(open_led), .en_q(en_q), .trim_q(trim_q),
   .en_chain(en_chain), .trim_chain(trim_chain)
);

// File: tb/led_cfg_loader_tb.sv
module led_cfg_loader_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CH  = 16;
   localparam int TW  = 7;
   localparam int TL  = CH * TW;
   localparam int NV  = 4;
   // {enable pattern, open-LED status applied before the strobe}
   localparam logic [31:0] VEC [NV] = '{
      {16'hA5C3, 16'h0001},
      {16'h8001, 16'hF00D},
      {16'h7FFE, 16'h8000},
      {16'h1234, 16'h5AA5}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic mode_sel = 1'b0, ser_clk = 1'b0, ser_in = 1'b0, lat_stb = 1'b0;
   logic [CH-1:0] open_led = '0;
   logic          ser_out;
   logic [CH-1:0] en_q;
   logic [TL-1:0] trim_q;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   led_cfg_loader u_dut (
      .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ser_clk(ser_clk),
      .ser_in(ser_in), .lat_stb(lat_stb), .open_led(open_led),
      .ser_out(ser_out), .en_q(en_q), .trim_q(trim_q)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", req, act, exp);
      end
   endtask

   task automatic pulse(input logic d, output logic so);
      so = ser_out;
      ser_in = d;
      ser_clk = 1'b1;
      @(negedge clk);
      ser_clk = 1'b0;
      @(negedge clk);
   endtask

   task automatic strobe();
      lat_stb = 1'b1;
      @(negedge clk);
      lat_stb = 1'b0;
      @(negedge clk);
   endtask

   task automatic shift_en_word(input logic [CH-1:0] v, output logic [CH-1:0] rb);
      logic b;
      for (int k = 0; k < CH; k++) begin
         pulse(v[CH-1-k], b);
         rb[CH-1-k] = b;
      end
   endtask

   task automatic shift_trim_word(input logic [TL-1:0] v, output logic [TL-1:0] rb);
      logic b;
      for (int k = 0; k < TL; k++) begin
         pulse(v[TL-1-k], b);
         rb[TL-1-k] = b;
      end
   endtask

   function automatic logic [TL-1:0] mk_trim(input int seed);
      logic [TL-1:0] v;
      for (int c = 0; c < CH; c++) v[c*TW +: TW] = 7'((c*37 + seed) & 'h7f);
      return v;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [CH-1:0] rb16, prev_stat, last_en;
      logic [TL-1:0] rb112, t1, t2;
      logic b;

      repeat (3) @(negedge clk);
      chk("R1 en_q at reset", 128'(en_q), 128'(0));
      chk("R1 trim_q at reset", 128'(trim_q), 128'(0));
      chk("R1 ser_out at reset", 128'(ser_out), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      // vector table: enable loads with status readback
      prev_stat = '0;
      last_en = '0;
      for (int i = 0; i < NV; i++) begin
         logic [CH-1:0] pat, stat;
         pat  = VEC[i][31:16];
         stat = VEC[i][15:0];
         shift_en_word(pat, rb16);
         chk("R5 en_q unchanged by shifting", 128'(en_q), 128'(last_en));
         chk("R6 status readback channel 15 first", 128'(rb16), 128'(prev_stat));
         open_led = stat;
         strobe();
         chk("R2 R4 en_q after strobe", 128'(en_q), 128'(pat));
         chk("R4 trim_q untouched by enable strobe", 128'(trim_q), 128'(0));
         chk("R7 ser_out is status bit 15", 128'(ser_out), 128'(stat[CH-1]));
         prev_stat = stat;
         last_en = pat;
      end

      // trim chain, first word
      mode_sel = 1'b1;
      @(negedge clk);
      t1 = mk_trim(5);
      shift_trim_word(t1, rb112);
      chk("R3 trim readback of reset chain", 128'(rb112), 128'(0));
      chk("R5 trim_q unchanged by shifting", 128'(trim_q), 128'(0));
      strobe();
      chk("R3 R4 trim_q after strobe", 128'(trim_q), 128'(t1));
      chk("R3 channel 3 field LSB at bit 21", 128'(trim_q[3*TW +: TW]), 128'((3*37+5) & 'h7f));
      chk("R4 en_q untouched by trim strobe", 128'(en_q), 128'(last_en));
      chk("R7 ser_out is trim stage 111", 128'(ser_out), 128'(t1[TL-1]));
      mode_sel = 1'b0;
      @(negedge clk);
      chk("R7 ser_out follows enable chain", 128'(ser_out), 128'(prev_stat[CH-1]));
      mode_sel = 1'b1;
      @(negedge clk);

      // second word: old word returns on ser_out
      t2 = mk_trim(77);
      shift_trim_word(t2, rb112);
      chk("R5 trim readback of previous word", 128'(rb112), 128'(t1));
      chk("R5 trim_q holds before strobe", 128'(trim_q), 128'(t1));
      strobe();
      chk("R3 trim_q second word", 128'(trim_q), 128'(t2));

      // shift pulses during strobe are blocked
      lat_stb = 1'b1;
      @(negedge clk);
      for (int k = 0; k < 3; k++) pulse(1'b1, b);
      lat_stb = 1'b0;
      @(negedge clk);
      strobe();
      chk("R8 trim_q after pulses under strobe", 128'(trim_q), 128'(t2));
      chk("R8 ser_out after pulses under strobe", 128'(ser_out), 128'(t2[TL-1]));

      // enable chain survived trim activity
      mode_sel = 1'b0;
      @(negedge clk);
      shift_en_word('0, rb16);
      chk("R3 enable chain idle in trim mode", 128'(rb16), 128'(prev_stat));
      chk("R5 en_q unchanged", 128'(en_q), 128'(last_en));

      // reset in mid-run
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 en_q cleared mid-run", 128'(en_q), 128'(0));
      chk("R1 trim_q cleared mid-run", 128'(trim_q), 128'(0));
      mode_sel = 1'b1;
      @(negedge clk);
      chk("R1 ser_out cleared mid-run", 128'(ser_out), 128'(0));
      rst_n = 1'b1;
      @(negedge clk);

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule